// File: doc/BRIEF.md
# UART Interrupt and Buffer-Status Controller

This block keeps the buffer flags of a UART and raises its interrupt request. The UART has a transmit data buffer that holds one byte and a receive data buffer that holds two. The transmit and receive shift logic report events as single-cycle strobes: the transmit byte moved into the shifter, a received byte arrived, or a parity, framing or overrun error occurred. A small register bus gives access to the status word, the control word, the transmit buffer and the receive buffer.

There are three causes, and each has its own enable. All three share one request line. That line gives a single-cycle pulse and does not say which cause fired, so software reads the status word to find out. For the receive cause, a control bit chooses whether the pulse fires when the first byte is held or when the buffer becomes full with two bytes.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset, the status word (address 0) reads 0x01, the control word (address 1) reads 0x00, and `irq` is low.
- R2: Writing address 2 loads the transmit byte onto `tx_data` and clears the transmit-empty flag (status bit 0). A `tx_load` strobe sets that flag again.
- R3: When status bit 0 goes from 0 to 1 and control bit 4 is 1, `irq` is high for exactly one cycle: the cycle after the strobe's clock edge. When control bit 4 is 0, no pulse is issued.
- R4: Each `rx_load` strobe pushes `rx_byte` into the two-entry receive buffer. Reading address 3 returns the oldest byte and removes it. Status bit 1 means at least one byte is held. Status bit 3 means two bytes are held.
- R5: When control bit 1 is 0, the receive pulse fires when status bit 1 rises. When control bit 1 is 1, it fires only when status bit 3 rises.
- R6: When control bit 5 is 0, receive events produce no pulse.
- R7: Status bits 4, 5 and 6 are sticky parity, framing and overrun flags, set by `err_set[0]`, `err_set[1]` and `err_set[2]`. Writing 1 to a bit at address 0 clears that flag. A set in the same cycle wins over the clear.
- R8: An `rx_load` while the buffer holds two bytes (and no read happens) drops the byte and sets the overrun flag.
- R9: When control bit 6 is 1, a pulse fires in the cycle any error flag goes from 0 to 1. A strobe on a flag that is already set gives no pulse.
- R10: Causes that fire in the same cycle produce a single one-cycle pulse.
- R11: Control bits 1, 4, 5 and 6 are writable. Every other control bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (a read of address 3 pops the receive buffer) |
| bus_addr | input | 2 | 0 status, 1 control, 2 transmit buffer, 3 receive buffer |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from the address |
| tx_load | input | 1 | Transmit buffer moved into the shifter |
| tx_data | output | DATA_W | Transmit buffer contents |
| rx_load | input | 1 | Received byte valid |
| rx_byte | input | DATA_W | Received byte |
| err_set | input | 3 | Error strobes: parity, framing, overrun |
| irq | output | 1 | Shared interrupt request pulse |

## Verification
The hardest cases to reach from the ports are the ones where several things land in the same cycle. One is three causes firing on one edge. Another is an error strobe arriving on a flag that is already sticky. The bench handles these by driving the event strobes on the same falling edge and then counting how many cycles `irq` stays high. The bench also fills the receive buffer to two bytes with the threshold bit set, then sends a third byte. This checks that the overrun is recorded, that the dropped byte never appears in the read order, and that the receive cause stays silent while no new flag rises.

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tx_load,
  output logic [DATA_W-1:0] tx_data,
  input  logic              rx_load,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic [2:0]        err_set,
  output logic              irq
);
  localparam logic [1:0] A_STAT = 2'd0;
  localparam logic [1:0] A_CTRL = 2'd1;
  localparam logic [1:0] A_TX   = 2'd2;
  localparam logic [1:0] A_RX   = 2'd3;
  localparam logic [1:0] FULL   = 2'd2;

  logic              rx_thr, tx_ie, rx_ie, err_ie;
  logic              tx_empty;
  logic [DATA_W-1:0] tx_buf, rx_q0, rx_q1;
  logic [1:0]        rx_cnt, cnt_nxt, wpos;
  logic [2:0]        err_flg, err_nxt, err_clr;
  logic              tx_nxt, rx_pop, rx_push, rx_ovr, rx_room;
  logic              tx_rise, rdy_rise, sec_rise, err_rise, irq_nxt;

  wire wr_stat = bus_wr && bus_addr == A_STAT;
  wire wr_ctrl = bus_wr && bus_addr == A_CTRL;
  wire wr_tx   = bus_wr && bus_addr == A_TX;

  assign rx_pop  = bus_rd && bus_addr == A_RX && rx_cnt != 2'd0;
  assign rx_room = rx_cnt != FULL || rx_pop;
  assign rx_push = rx_load && rx_room;
  assign rx_ovr  = rx_load && !rx_room;
  assign wpos    = rx_cnt - {1'b0, rx_pop};
  assign cnt_nxt = wpos + {1'b0, rx_push};

  assign tx_nxt  = wr_tx ? 1'b0 : (tx_load ? 1'b1 : tx_empty);
  assign err_clr = wr_stat ? bus_wdata[6:4] : 3'b000;
  assign err_nxt = (err_flg & ~err_clr) | err_set | {rx_ovr, 2'b00};

  assign tx_rise  = tx_nxt && !tx_empty;
  assign rdy_rise = cnt_nxt != 2'd0 && rx_cnt == 2'd0;
  assign sec_rise = cnt_nxt == FULL && rx_cnt != FULL;
  assign err_rise = |(err_nxt & ~err_flg);
  assign irq_nxt  = (tx_ie && tx_rise) || (rx_ie && (rx_thr ? sec_rise : rdy_rise))
                 || (err_ie && err_rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {rx_thr, tx_ie, rx_ie, err_ie} <= '0;
      tx_empty <= 1'b1;
      tx_buf   <= '0;
      rx_q0    <= '0;
      rx_q1    <= '0;
      rx_cnt   <= '0;
      err_flg  <= '0;
      irq      <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        rx_thr <= bus_wdata[1];
        tx_ie  <= bus_wdata[4];
        rx_ie  <= bus_wdata[5];
        err_ie <= bus_wdata[6];
      end
      if (wr_tx) tx_buf <= bus_wdata;
      if (rx_pop) rx_q0 <= rx_q1;
      if (rx_push) begin
        if (wpos == 2'd0) rx_q0 <= rx_byte;
        else              rx_q1 <= rx_byte;
      end
      tx_empty <= tx_nxt;
      rx_cnt   <= cnt_nxt;
      err_flg  <= err_nxt;
      irq      <= irq_nxt;
    end
  end

  assign tx_data = tx_buf;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_STAT:  bus_rdata[6:0] = {err_flg, rx_cnt == FULL, 1'b0, rx_cnt != 2'd0, tx_empty};
      A_CTRL:  bus_rdata[6:0] = {err_ie, rx_ie, tx_ie, 2'b00, rx_thr, 1'b0};
      A_TX:    bus_rdata = tx_buf;
      default: bus_rdata = rx_q0;
    endcase
  end

  AST_TX_LOAD_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load && !wr_tx |=> tx_empty); // R2
  AST_TX_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tx |=> !tx_empty); // R2
  AST_NO_IRQ_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_ie || rx_ie || err_ie) |=> !irq); // R3
  AST_RX_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= FULL); // R4
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stat |=> (err_flg & $past(err_flg)) == $past(err_flg)); // R7
  AST_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    rx_load && rx_cnt == FULL && !rx_pop |=> err_flg[2] && rx_cnt == FULL); // R8
endmodule

// File: tb/test_uart_irq_ctrl.sv
module test_uart_irq_ctrl;
  logic       clk = 0, rst_n = 0;
  logic       bus_wr = 0, bus_rd = 0, tx_load = 0, rx_load = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, rx_byte = 0;
  logic [2:0] err_set = 0;
  logic [7:0] bus_rdata, tx_data;
  logic       irq;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  uart_irq_ctrl #(.DATA_W(8)) i_uart_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_load(tx_load), .tx_data(tx_data),
    .rx_load(rx_load), .rx_byte(rx_byte), .err_set(err_set), .irq(irq));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic pop(output logic [7:0] d);
    @(negedge clk); bus_addr = 2'd3; bus_rd = 1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic strobe(input logic t, input logic r, input logic [7:0] b, input logic [2:0] e);
    @(negedge clk); tx_load = t; rx_load = r; rx_byte = b; err_set = e;
    @(negedge clk); tx_load = 0; rx_load = 0; err_set = 0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    peek(2'd0, d); chk("R1 status", d, 8'h01);
    peek(2'd1, d); chk("R1 control", d, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_ctrl;
    logic [7:0] d;
    wr(2'd1, 8'hFF); peek(2'd1, d); chk("R11 control mask", d, 8'h72);
    wr(2'd1, 8'h00);
  endtask

  task automatic t_tx;
    logic [7:0] d;
    wr(2'd2, 8'hA5);
    chk("R2 tx_data", tx_data, 8'hA5);
    peek(2'd0, d); chk("R2 empty cleared", d & 8'h01, 8'h00);
    strobe(1, 0, 0, 0);
    peek(2'd0, d); chk("R2 empty set", d & 8'h01, 8'h01);
    wr(2'd1, 8'h10); wr(2'd2, 8'h5A);
    @(negedge clk); tx_load = 1;
    @(negedge clk); tx_load = 0;
    chk("R3 tx pulse", {7'd0, irq}, 8'h01);
    @(negedge clk); chk("R3 pulse one cycle", {7'd0, irq}, 8'h00);
    wr(2'd1, 8'h00); wr(2'd2, 8'h33);
    @(negedge clk); tx_load = 1;
    @(negedge clk); tx_load = 0;
    chk("R3 disabled no pulse", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_rx;
    logic [7:0] d;
    wr(2'd1, 8'h20);
    @(negedge clk); rx_load = 1; rx_byte = 8'h11;
    @(negedge clk); rx_load = 0;
    chk("R5 ready pulse", {7'd0, irq}, 8'h01);
    peek(2'd0, d); chk("R4 ready", d & 8'h0A, 8'h02);
    @(negedge clk); rx_load = 1; rx_byte = 8'h22;
    @(negedge clk); rx_load = 0;
    chk("R5 no pulse on second", {7'd0, irq}, 8'h00);
    peek(2'd0, d); chk("R4 second", d & 8'h0A, 8'h0A);
    pop(d); chk("R4 oldest first", d, 8'h11);
    peek(2'd0, d); chk("R4 one left", d & 8'h0A, 8'h02);
    pop(d); chk("R4 next byte", d, 8'h22);
    peek(2'd0, d); chk("R4 empty", d & 8'h0A, 8'h00);
  endtask

  task automatic t_thresh;
    logic [7:0] d;
    wr(2'd1, 8'h22);
    @(negedge clk); rx_load = 1; rx_byte = 8'h44;
    @(negedge clk); rx_load = 0;
    chk("R5 thr1 no first pulse", {7'd0, irq}, 8'h00);
    @(negedge clk); rx_load = 1; rx_byte = 8'h55;
    @(negedge clk); rx_load = 0;
    chk("R5 thr1 second pulse", {7'd0, irq}, 8'h01);
    @(negedge clk); rx_load = 1; rx_byte = 8'h66;
    @(negedge clk); rx_load = 0;
    chk("R8 no rx pulse on overrun", {7'd0, irq}, 8'h00);
    peek(2'd0, d); chk("R8 overrun flag", d & 8'h4A, 8'h4A);
    pop(d); chk("R8 first kept", d, 8'h44);
    pop(d); chk("R8 second kept", d, 8'h55);
    peek(2'd0, d); chk("R8 dropped byte", d & 8'h02, 8'h00);
    wr(2'd0, 8'h70);
    peek(2'd0, d); chk("R7 clear all", d & 8'h70, 8'h00);
  endtask

  task automatic t_rx_off;
    logic [7:0] d;
    wr(2'd1, 8'h00);
    @(negedge clk); rx_load = 1; rx_byte = 8'h77;
    @(negedge clk); rx_load = 0;
    chk("R6 rx disabled", {7'd0, irq}, 8'h00);
    pop(d); chk("R6 byte still stored", d, 8'h77);
  endtask

  task automatic t_err;
    logic [7:0] d;
    wr(2'd1, 8'h40);
    @(negedge clk); err_set = 3'b001;
    @(negedge clk); err_set = 0;
    chk("R9 parity pulse", {7'd0, irq}, 8'h01);
    peek(2'd0, d); chk("R7 parity flag", d & 8'h70, 8'h10);
    @(negedge clk); err_set = 3'b001;
    @(negedge clk); err_set = 0;
    chk("R9 already set no pulse", {7'd0, irq}, 8'h00);
    @(negedge clk); err_set = 3'b010;
    @(negedge clk); err_set = 0;
    chk("R9 framing pulse", {7'd0, irq}, 8'h01);
    wr(2'd0, 8'h10);
    peek(2'd0, d); chk("R7 clear parity only", d & 8'h70, 8'h20);
    @(negedge clk); bus_wr = 1; bus_addr = 2'd0; bus_wdata = 8'h20; err_set = 3'b010;
    @(negedge clk); bus_wr = 0; err_set = 0;
    peek(2'd0, d); chk("R7 set wins clear", d & 8'h70, 8'h20);
    wr(2'd0, 8'h70);
    peek(2'd0, d); chk("R7 all cleared", d & 8'h70, 8'h00);
  endtask

  task automatic t_multi;
    logic [7:0] d;
    int hi = 0;
    wr(2'd1, 8'h70); wr(2'd2, 8'h99);
    @(negedge clk); tx_load = 1; rx_load = 1; rx_byte = 8'h12; err_set = 3'b001;
    @(negedge clk); tx_load = 0; rx_load = 0; err_set = 0;
    for (int i = 0; i < 4; i++) begin
      if (irq) hi++;
      @(negedge clk);
    end
    chk("R10 single pulse", 8'(hi), 8'd1);
    pop(d);
    wr(2'd0, 8'h70); wr(2'd1, 8'h00);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_ctrl();
    t_tx();
    t_rx();
    t_thresh();
    t_rx_off();
    t_err();
    t_multi();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule